// File: doc/BRIEF.md
# Two-Phase Piezo Step Sequencer

This block sits between a motion controller and the DAC feeding a piezo actuator's drive amplifier. A stiff, lightly damped actuator hit with a full step overshoots to nearly twice its travel and then rings for a long time. The sequencer avoids this by splitting every requested position change into two writes.

The first write is the midpoint between the present code and the new one. It is held for half of the actuator's mechanical resonance period. The momentum gained in the first quarter cycle is used up against the actuator's stiffness in the second quarter, so the mass comes to rest at the new position. The second write, the final target, then holds it there.

The controller presents a target code with a one-cycle valid strobe, plus a hold length in clock cycles that is tuned to the actuator. The block drives the DAC code, a one-cycle write strobe for each DAC update, and a busy flag. A target that arrives during a move waits in a single-entry slot. A newer arrival replaces it.

Top module: `piezo_step_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to idle: `dac_code` becomes `REST_CODE` (default 16'h8000), `dac_wr` and `busy` are 0, and any waiting target is discarded.
- R2: When the block is idle and `tgt_valid` is sampled with a `tgt_code` different from `dac_code`, the following cycle shows the midpoint on `dac_code`, with `dac_wr` high and `busy` high.
- R3: The midpoint is computed with one spare bit so that the sum of the two codes cannot wrap, and it rounds toward the present code. Upward moves use floor((cur+N)/2). Downward moves use ceil((cur+N)/2). It always lies between the present code and the target.
- R4: The midpoint stays on `dac_code` for exactly H cycles, where H is `half_cycles` as sampled in the accepting cycle. Then `dac_code` becomes the target, with `dac_wr` high. Changes to `half_cycles` during a move do not affect that move.
- R5: A `half_cycles` value of 0 acts as 1, so the midpoint is visible for one cycle.
- R6: Once the final value is written and nothing is waiting, `dac_code` holds and `dac_wr` stays low until a new target is accepted.
- R7: A target equal to the present `dac_code`, presented while idle, causes no write and leaves `busy` low.
- R8: `busy` is high from the midpoint cycle until the cycle that shows the final value. In that cycle it drops, unless a target is waiting.
- R9: A target sampled while a move is in progress is kept in one pending slot, and a later arrival overwrites it. It starts one cycle after the final write: its midpoint, computed from that final value, appears on the next cycle, and `busy` stays high in between.
- R10: `dac_wr` is high for exactly the cycles in which a new value is written to `dac_code`. This gives two writes per move whose target differs from the present code, and a value never changes without `dac_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tgt_valid | input | 1 | One-cycle strobe: `tgt_code` holds a new target |
| tgt_code | input | CODE_W | Requested DAC code |
| half_cycles | input | CNT_W | Midpoint hold length in clocks (half resonance period) |
| dac_code | output | CODE_W | Code driven to the DAC |
| dac_wr | output | 1 | One-cycle DAC write strobe |
| busy | output | 1 | Move in progress or target waiting |

## Verification
A target sampled at edge a gives the midpoint write in the cycle right after a, and the final write exactly max(H,1) edges later. A waiting target produces its midpoint write one edge after the final write, and its own final write max(H,1) edges after that. The driver computes both due cycles from these rules when it issues a target and queues each write with its code and cycle. The monitor samples on the falling edge and compares every `dac_wr` cycle against the head of the queue. A write that arrives early, late or with no entry in the queue is therefore reported. `busy` is sampled at the final-write cycles and during idle gaps.

// File: rtl/pst_pkg.sv
package pst_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } pst_state_t;
endpackage

// File: rtl/pst_midpoint.sv
module pst_midpoint #(
  parameter int W = 16
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] tgt,
  output logic [W-1:0] mid
);
  localparam logic [W:0] ONE = {{W{1'b0}}, 1'b1};

  logic [W:0] sum;
  logic [W:0] sum_up;
  logic       rising;

  always_comb begin
    sum    = {1'b0, cur} + {1'b0, tgt};
    sum_up = sum + ONE;
    rising = tgt > cur;
    // floor toward a lower present code, ceil toward a higher one
    mid    = rising ? sum[W:1] : sum_up[W:1];
  end
endmodule

// File: rtl/pst_hold_timer.sv
module pst_hold_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= (load_val == '0) ? ONE : load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - ONE;
    end
  end

  assign expire = (cnt == ONE);
endmodule

// File: rtl/pst_pending.sv
module pst_pending #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wr_code,
  input  logic         clr,
  output logic         valid,
  output logic [W-1:0] code
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      code  <= '0;
    end else if (wr) begin
      valid <= 1'b1;
      code  <= wr_code;
    end else if (clr) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/piezo_step_seq.sv
module piezo_step_seq #(
  parameter int              CODE_W    = 16,
  parameter int              CNT_W     = 16,
  parameter logic [CODE_W-1:0] REST_CODE = 16'h8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tgt_valid,
  input  logic [CODE_W-1:0] tgt_code,
  input  logic [CNT_W-1:0]  half_cycles,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_wr,
  output logic              busy
);
  import pst_pkg::*;

  pst_state_t        state;
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] final_q;
  logic              wr_q;

  logic              pend_valid;
  logic [CODE_W-1:0] pend_code;
  logic              pend_wr;
  logic              take_req;
  logic [CODE_W-1:0] next_tgt;
  logic [CODE_W-1:0] mid;
  logic              start;
  logic              expire;
  logic              finish;

  always_comb begin
    take_req = (state == ST_IDLE) && (tgt_valid || pend_valid);
    next_tgt = tgt_valid ? tgt_code : pend_code;
    start    = take_req && (next_tgt != code_q);
    pend_wr  = (state == ST_HOLD) && tgt_valid;
    finish   = (state == ST_HOLD) && expire;
  end

  pst_midpoint #(.W(CODE_W)) u_mid (
    .cur (code_q),
    .tgt (next_tgt),
    .mid (mid)
  );

  pst_hold_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (start),
    .load_val (half_cycles),
    .expire   (expire)
  );

  pst_pending #(.W(CODE_W)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .wr      (pend_wr),
    .wr_code (tgt_code),
    .clr     (take_req),
    .valid   (pend_valid),
    .code    (pend_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      code_q  <= REST_CODE;
      final_q <= REST_CODE;
      wr_q    <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      if (start) begin
        state   <= ST_HOLD;
        code_q  <= mid;
        final_q <= next_tgt;
        wr_q    <= 1'b1;
      end else if (finish) begin
        state  <= ST_IDLE;
        code_q <= final_q;
        wr_q   <= 1'b1;
      end
    end
  end

  assign dac_code = code_q;
  assign dac_wr   = wr_q;
  assign busy     = (state == ST_HOLD) || pend_valid;
endmodule

// File: rtl/pst_checker.sv
module pst_checker #(
  parameter int CODE_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              tgt_valid,
  input logic [CODE_W-1:0] tgt_code,
  input logic [CODE_W-1:0] dac_code,
  input logic              dac_wr,
  input logic              busy
);
  // R2
  start_mid_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && tgt_valid && (tgt_code != dac_code)) |=> (dac_wr && busy));

  // R3
  mid_between_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |->
      (($past(tgt_code) >= $past(dac_code)) ?
        (dac_code >= $past(dac_code) && dac_code <= $past(tgt_code)) :
        (dac_code <= $past(dac_code) && dac_code >= $past(tgt_code))));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !tgt_valid) |=> (!dac_wr && $stable(dac_code)));

  // R7
  same_code_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && tgt_valid && (tgt_code == dac_code)) |=> (!dac_wr && !busy));

  // R10
  wr_on_change_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(dac_code) |-> dac_wr);
endmodule

bind piezo_step_seq pst_checker #(.CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tgt_valid (tgt_valid),
  .tgt_code  (tgt_code),
  .dac_code  (dac_code),
  .dac_wr    (dac_wr),
  .busy      (busy)
);

// File: tb/piezo_step_seq_test.sv
`timescale 1ns/1ps
module piezo_step_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tgt_valid = 1'b0;
  logic [15:0] tgt_code = '0;
  logic [15:0] half_cycles = 16'd4;
  logic [15:0] dac_code;
  logic        dac_wr;
  logic        busy;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [15:0] model_cur = 16'h8000;

  logic [15:0] q_code[$];
  int          q_cyc[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  piezo_step_seq uut (
    .clk(clk), .rst(rst), .tgt_valid(tgt_valid), .tgt_code(tgt_code),
    .half_cycles(half_cycles), .dac_code(dac_code), .dac_wr(dac_wr), .busy(busy)
  );

  function automatic logic [15:0] exp_mid(logic [15:0] c, logic [15:0] n);
    if (n > c) return c + (n - c) / 2;
    else       return c - (c - n) / 2;
  endfunction

  task automatic push(logic [15:0] code, int at, string tag);
    q_code.push_back(code); q_cyc.push_back(at); q_tag.push_back(tag);
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: every write compared against the head of the scoreboard
  always @(negedge clk) begin
    if (!rst && dac_wr) begin
      if (q_code.size() == 0) begin
        check(1'b0, "R10 unexpected write", int'(dac_code), -1);
      end else begin
        logic [15:0] ec; int ey; string et;
        ec = q_code.pop_front(); ey = q_cyc.pop_front(); et = q_tag.pop_front();
        check(dac_code == ec, et, int'(dac_code), int'(ec));
        check(cyc == ey, {et, " timing"}, cyc, ey);
      end
    end
  end

  task automatic wait_cyc(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic send(logic [15:0] code, logic [15:0] h, output int acc);
    @(negedge clk);
    tgt_code = code; half_cycles = h; tgt_valid = 1'b1;
    acc = cyc + 1;
    @(negedge clk);
    tgt_valid = 1'b0;
  endtask

  task automatic move(logic [15:0] code, logic [15:0] h, string tag);
    int a; int hh;
    hh = (h == 0) ? 1 : int'(h);
    @(negedge clk);
    a = cyc + 1;
    push(exp_mid(model_cur, code), a, {tag, " R2 R3 midpoint"});
    push(code, a + hh, {tag, " R4 final"});
    tgt_code = code; half_cycles = h; tgt_valid = 1'b1;
    @(negedge clk);
    tgt_valid = 1'b0;
    wait_cyc(a + hh);
    check(busy == 1'b0, {tag, " R8 busy drops at final"}, int'(busy), 0);
    model_cur = code;
    wait_cyc(a + hh + 2);
    check(dac_code == code, {tag, " R6 holds"}, int'(dac_code), int'(code));
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int a;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(dac_code == 16'h8000, "R1 rest code", int'(dac_code), 16'h8000);
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(dac_wr == 1'b0, "R1 wr", int'(dac_wr), 0);

    move(16'h9001, 16'd5, "up");
    move(16'h1234, 16'd3, "down odd");
    move(16'h0000, 16'd0, "R5 zero hold");
    move(16'hFFFF, 16'd2, "R3 full span");
    move(16'hFFFE, 16'd2, "R3 step of one");

    // R7 equal target: no write, busy low
    @(negedge clk); tgt_code = model_cur; tgt_valid = 1'b1;
    @(negedge clk); tgt_valid = 1'b0;
    check(busy == 1'b0, "R7 busy after equal", int'(busy), 0);
    repeat (5) @(negedge clk);
    check(dac_code == model_cur, "R7 code kept", int'(dac_code), int'(model_cur));

    // R4 half_cycles change during hold is ignored
    @(negedge clk);
    a = cyc + 1;
    push(exp_mid(model_cur, 16'h3000), a, "R4 mid");
    push(16'h3000, a + 6, "R4 sampled hold length");
    tgt_code = 16'h3000; half_cycles = 16'd6; tgt_valid = 1'b1;
    @(negedge clk); tgt_valid = 1'b0; half_cycles = 16'd1;
    wait_cyc(a + 8);
    model_cur = 16'h3000;

    // R9 pending slot, later arrival overwrites earlier
    @(negedge clk);
    a = cyc + 1;
    push(exp_mid(model_cur, 16'h4000), a, "R9 first mid");
    push(16'h4000, a + 8, "R9 first final");
    push(exp_mid(16'h4000, 16'h6000), a + 9, "R9 pending mid");
    push(16'h6000, a + 17, "R9 pending final");
    tgt_code = 16'h4000; half_cycles = 16'd8; tgt_valid = 1'b1;
    @(negedge clk); tgt_valid = 1'b0;
    @(negedge clk); tgt_code = 16'h2000; tgt_valid = 1'b1;
    @(negedge clk); tgt_code = 16'h6000;
    @(negedge clk); tgt_valid = 1'b0;
    wait_cyc(a + 8);
    check(busy == 1'b1, "R9 busy kept with pending", int'(busy), 1);
    wait_cyc(a + 17);
    check(busy == 1'b0, "R8 busy low after pending final", int'(busy), 0);
    model_cur = 16'h6000;
    repeat (4) @(negedge clk);

    check(q_code.size() == 0, "R10 all writes seen", q_code.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule